// File: doc/BRIEF.md
# Banked Interrupt Aggregator

This block collects 64 level-sensitive peripheral interrupt lines and 8 level-sensitive local lines into two processor-facing requests. The normal request (`irq_o`) is raised whenever any line whose enable bit is set is active. The fast request (`fiq_o`) follows the raw level of exactly one line, chosen by a 7-bit selector, and does not look at the enable bits.

Software reaches the block through a simple 32-bit word register port with byte addresses. Enable masks are never written directly. One register ORs ones into a mask and a separate register clears the bits written as one. Reading a clear register returns the inverse of the mask it serves. A summary word packs the masked local lines, one "any enabled line active" flag per peripheral bank, and copies of the pending state of eleven chosen peripheral lines. Read data, `irq_o` and `fiq_o` are all registered.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After synchronous reset, all enable masks, the fast enable and the fast selector are zero. `irq_o` and `fiq_o` stay low even when input lines are high.
- R2: A write to offset 0x10 ORs the data into enables of lines 31:0. A write to 0x14 ORs it into enables of lines 63:32. A write to 0x18 ORs data bits 7:0 into the local enables. Each of these registers reads back its mask, and the local mask is zero-extended.
- R3: A write to 0x1C, 0x20 or 0x24 clears every enable bit (low bank, high bank, local) that is written as 1 and leaves the other bits unchanged.
- R4: A read of 0x1C, 0x20 or 0x24 returns the full 32-bit inverse of the matching mask. For the local mask the upper 24 bits read as ones.
- R5: A read of 0x04 returns lines 31:0 ANDed with their enables. A read of 0x08 returns lines 63:32 ANDed with their enables.
- R6: The summary word at 0x00 carries the enabled local lines in bits 7:0. Bit 8 is set when any enabled line in 31:0 is active. Bit 9 is set when any enabled line in 63:32 is active.
- R7: Summary bits 10 through 20 copy the enabled-pending state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. All higher bits are zero.
- R8: The register at 0x0C holds the fast selector in bits 6:0 and the fast enable in bit 7, and it reads back the same way. While the fast enable is set, `fiq_o` follows the raw level of peripheral line `sel` for `sel` < 64, or of local line `sel`−64 for `sel` 64–71, whatever the enable masks hold. While the fast enable is clear, `fiq_o` is low.
- R9: Selector values 72 to 127 match no line, and `fiq_o` stays low for them.
- R10: `irq_o` is high exactly when at least one enabled peripheral or local line is active.
- R11: Offsets above 0x24, and any address with bits 1:0 not zero, read as 0. Writes to them, and writes to the read-only offsets 0x00, 0x04 and 0x08, change no state.
- R12: `irq_o`, `fiq_o` and `bus_rdata` are registered. Each reflects the inputs and state present at the previous rising clock edge, so an enable write and a line change in the same cycle are seen one edge apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_lvl | input | 64 | Peripheral interrupt levels |
| local_lvl | input | 8 | Local interrupt levels |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| irq_o | output | 1 | Masked aggregate request |
| fiq_o | output | 1 | Raw level of the selected source |

## Verification
Two functions can meet in the same cycle: a clear-register write that removes an enable, and the rising edge of the line that the enable guards. The bench raises peripheral line 5 in the same cycle as it writes a clear of enable bit 5. It then expects `irq_o` to be high for exactly one edge, because the output register sees the new level together with the old mask, and low after the next edge. A second collision, a selector write while the chosen line is already high, is judged by expecting `fiq_o` only on the edge after the selector register has taken its new value.

// File: rtl/birq_pkg.sv
package birq_pkg;

  // Word indices (byte offset / 4). This layout assumes two peripheral banks.
  localparam int unsigned WI_SUMMARY  = 0;
  localparam int unsigned WI_PEND0    = 1;   // banks at WI_PEND0 + b
  localparam int unsigned WI_FASTCTL  = 3;
  localparam int unsigned WI_SET0     = 4;   // banks at WI_SET0 + b
  localparam int unsigned WI_SET_LOC  = 6;
  localparam int unsigned WI_CLR0     = 7;   // banks at WI_CLR0 + b
  localparam int unsigned WI_CLR_LOC  = 9;

  localparam int unsigned MIRROR_N = 11;

  // Peripheral line copied into summary bit (LN + NBANK + k).
  function automatic int unsigned mirror_line(input int unsigned k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      4: return 19;
      5: return 53;
      6: return 54;
      7: return 55;
      8: return 56;
      9: return 57;
      default: return 62;
    endcase
  endfunction

endpackage

// File: rtl/birq_mask_reg.sv
module birq_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (set_we) mask_q <= mask_q | bits;
    else if (clr_we) mask_q <= mask_q & ~bits;
  end

  // R2
  set_or_chk: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask_q & $past(bits)) == $past(bits)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((mask_q & $past(bits)) == '0));

endmodule

// File: rtl/birq_fiq_pick.sv
module birq_fiq_pick #(
  parameter int unsigned PN    = 64,
  parameter int unsigned LN    = 8,
  parameter int unsigned SEL_W = 7
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  input  logic [PN-1:0]    periph,
  input  logic [LN-1:0]    loc,
  output logic             hit
);

  localparam int unsigned PIW = $clog2(PN);
  localparam int unsigned LIW = $clog2(LN);

  logic [LIW-1:0] loff;
  assign loff = LIW'(sel - SEL_W'(PN));

  always_comb begin
    hit = 1'b0;
    if (en) begin
      if (sel < SEL_W'(PN))           hit = periph[sel[PIW-1:0]];
      else if (sel < SEL_W'(PN + LN)) hit = loc[loff];
    end
  end

endmodule

// File: rtl/birq_summary.sv
module birq_summary #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NBANK = 2,
  parameter int unsigned LN    = 8
) (
  input  logic [NBANK*DW-1:0] pend,
  input  logic [LN-1:0]       pend_loc,
  output logic [DW-1:0]       word
);
  import birq_pkg::*;

  always_comb begin
    word = '0;
    word[LN-1:0] = pend_loc;
    for (int b = 0; b < NBANK; b++)
      word[LN + b] = |pend[b*DW +: DW];
    for (int k = 0; k < MIRROR_N; k++)
      word[LN + NBANK + k] = pend[mirror_line(k)];
  end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NBANK  = 2,
  parameter int unsigned LN     = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SEL_W  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NBANK*DW-1:0] periph_lvl,
  input  logic [LN-1:0]       local_lvl,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq_o,
  output logic                fiq_o
);
  import birq_pkg::*;

  localparam int unsigned PN     = NBANK * DW;
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned PIW    = $clog2(PN);

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic [PN-1:0]     en_periph;
  logic [LN-1:0]     en_loc;
  logic [PN-1:0]     pend_periph;
  logic [LN-1:0]     pend_loc;
  logic [SEL_W-1:0]  fast_sel_q;
  logic              fast_en_q;
  logic [DW-1:0]     summary_w;
  logic              fast_hit;
  logic [DW-1:0]     rd_next;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  // Peripheral enable banks
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic set_hit, clr_hit;
    assign set_hit = bus_we && aligned && (widx == WIDX_W'(WI_SET0 + b));
    assign clr_hit = bus_we && aligned && (widx == WIDX_W'(WI_CLR0 + b));
    birq_mask_reg #(.W(DW)) u_mask (
      .clk(clk), .rst(rst), .set_we(set_hit), .clr_we(clr_hit),
      .bits(bus_wdata), .mask_q(en_periph[b*DW +: DW])
    );
  end

  // Local enable mask
  logic loc_set, loc_clr;
  assign loc_set = bus_we && aligned && (widx == WIDX_W'(WI_SET_LOC));
  assign loc_clr = bus_we && aligned && (widx == WIDX_W'(WI_CLR_LOC));
  birq_mask_reg #(.W(LN)) u_loc_mask (
    .clk(clk), .rst(rst), .set_we(loc_set), .clr_we(loc_clr),
    .bits(bus_wdata[LN-1:0]), .mask_q(en_loc)
  );

  // Fast-request control
  always_ff @(posedge clk) begin
    if (rst) begin
      fast_sel_q <= '0;
      fast_en_q  <= 1'b0;
    end else if (bus_we && aligned && widx == WIDX_W'(WI_FASTCTL)) begin
      fast_sel_q <= bus_wdata[SEL_W-1:0];
      fast_en_q  <= bus_wdata[SEL_W];
    end
  end

  assign pend_periph = periph_lvl & en_periph;
  assign pend_loc    = local_lvl & en_loc;

  birq_summary #(.DW(DW), .NBANK(NBANK), .LN(LN)) u_summary (
    .pend(pend_periph), .pend_loc(pend_loc), .word(summary_w)
  );

  birq_fiq_pick #(.PN(PN), .LN(LN), .SEL_W(SEL_W)) u_fast (
    .sel(fast_sel_q), .en(fast_en_q), .periph(periph_lvl), .loc(local_lvl),
    .hit(fast_hit)
  );

  // Read mux
  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (widx == WIDX_W'(WI_SUMMARY)) rd_next = summary_w;
      if (widx == WIDX_W'(WI_FASTCTL)) rd_next[SEL_W:0] = {fast_en_q, fast_sel_q};
      if (widx == WIDX_W'(WI_SET_LOC)) rd_next[LN-1:0] = en_loc;
      if (widx == WIDX_W'(WI_CLR_LOC)) rd_next = ~{{(DW-LN){1'b0}}, en_loc};
      for (int b = 0; b < NBANK; b++) begin
        if (widx == WIDX_W'(WI_PEND0 + b)) rd_next = pend_periph[b*DW +: DW];
        if (widx == WIDX_W'(WI_SET0 + b))  rd_next = en_periph[b*DW +: DW];
        if (widx == WIDX_W'(WI_CLR0 + b))  rd_next = ~en_periph[b*DW +: DW];
      end
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_o     <= (|pend_periph) || (|pend_loc);
      fiq_o     <= fast_hit;
    end
  end

  // R9
  fast_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_sel_q >= SEL_W'(PN + LN)) |=> !fiq_o);

  // R8
  fast_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_en_q && fast_sel_q < SEL_W'(PN) && periph_lvl[fast_sel_q[PIW-1:0]]) |=> fiq_o);

  // R10
  irq_local_chk: assert property (@(posedge clk) disable iff (rst)
    ((local_lvl & en_loc) != '0) |=> irq_o);

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en_periph == '0 && en_loc == '0) |=> !irq_o);

  // R11
  undef_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (!aligned || widx > WIDX_W'(WI_CLR_LOC)))
      |=> ($stable(en_periph) && $stable(en_loc) && $stable(fast_sel_q) && $stable(fast_en_q)));

endmodule

// File: tb/banked_irq_ctrl_bench.sv
`timescale 1ns/1ps
module banked_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] periph_lvl = '0;
  logic [7:0]  local_lvl = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Model of the enable masks, kept by the bench
  logic [63:0] m_en = '0;
  logic [7:0]  m_el = '0;

  always #2.5 clk = ~clk;

  banked_irq_ctrl u_banked_irq_ctrl (
    .clk(clk), .rst(rst), .periph_lvl(periph_lvl), .local_lvl(local_lvl),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 v = bus_rdata;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] exp_summary(input logic [63:0] p, input logic [7:0] l);
    int tab [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
    logic [63:0] pe;
    logic [31:0] s;
    pe = p & m_en;
    s = '0;
    s[7:0] = l & m_el;
    s[8] = |pe[31:0];
    s[9] = |pe[63:32];
    for (int k = 0; k < 11; k++) s[10 + k] = pe[tab[k]];
    return s;
  endfunction

  task automatic clear_all();
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    m_en = '0; m_el = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    periph_lvl = '1; local_lvl = '1;
    settle();
    check("R1 irq_o after reset", {31'b0, irq_o}, 32'h0);
    check("R1 fiq_o after reset", {31'b0, fiq_o}, 32'h0);
    rd(8'h10, v); check("R1 enable low", v, 32'h0);
    rd(8'h14, v); check("R1 enable high", v, 32'h0);
    rd(8'h18, v); check("R1 enable local", v, 32'h0);
    rd(8'h0C, v); check("R1 fast control", v, 32'h0);
    periph_lvl = '0; local_lvl = '0;
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    wr(8'h10, 32'h0000_00F0);
    wr(8'h10, 32'h0000_0F00); m_en[31:0] = 32'h0000_0FF0;
    rd(8'h10, v); check("R2 set low ORs", v, 32'h0000_0FF0);
    wr(8'h14, 32'h8000_0001); m_en[63:32] = 32'h8000_0001;
    rd(8'h14, v); check("R2 set high", v, 32'h8000_0001);
    wr(8'h18, 32'hFFFF_FF05); m_el = 8'h05;
    rd(8'h18, v); check("R2 set local zero-extended", v, 32'h0000_0005);
    wr(8'h1C, 32'h0000_0330); m_en[31:0] = 32'h0000_0CC0;
    rd(8'h10, v); check("R3 clear low", v, 32'h0000_0CC0);
    wr(8'h20, 32'h8000_0000); m_en[63:32] = 32'h0000_0001;
    rd(8'h14, v); check("R3 clear high", v, 32'h0000_0001);
    wr(8'h24, 32'h0000_0001); m_el = 8'h04;
    rd(8'h18, v); check("R3 clear local", v, 32'h0000_0004);
  endtask

  task automatic t_disable_read();
    logic [31:0] v;
    rd(8'h1C, v); check("R4 inverse low", v, ~m_en[31:0]);
    rd(8'h20, v); check("R4 inverse high", v, ~m_en[63:32]);
    rd(8'h24, v); check("R4 inverse local", v, ~{24'h0, m_el});
  endtask

  task automatic t_pending();
    logic [31:0] v;
    clear_all();
    wr(8'h10, 32'h0000_FFFF); wr(8'h14, 32'hFFFF_0000);
    m_en = 64'hFFFF_0000_0000_FFFF;
    periph_lvl = 64'hAAAA_5555_1234_ABCD;
    rd(8'h04, v); check("R5 pending low", v, 32'h0000_ABCD);
    rd(8'h08, v); check("R5 pending high", v, 32'hAAAA_0000);
    periph_lvl = 64'h0000_FFFF_FFFF_0000;
    rd(8'h04, v); check("R5 pending low masked out", v, 32'h0);
    rd(8'h08, v); check("R5 pending high masked out", v, 32'h0);
    periph_lvl = '0;
  endtask

  task automatic t_summary();
    logic [31:0] v;
    int lines [8] = '{7, 9, 62, 57, 18, 3, 40, 10};
    clear_all();
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'h0000_00F0);
    m_en = '1; m_el = 8'hF0;
    foreach (lines[i]) begin
      periph_lvl = 64'h1 << lines[i];
      rd(8'h00, v); check($sformatf("R7 summary line %0d", lines[i]), v, exp_summary(periph_lvl, local_lvl));
    end
    periph_lvl = '0; local_lvl = 8'h3C;
    rd(8'h00, v); check("R6 summary local masked", v, 32'h0000_0030);
    periph_lvl = 64'h0000_0100_0000_0000; local_lvl = '0;
    rd(8'h00, v); check("R6 summary high bank only", v, 32'h0000_0200);
    periph_lvl = 64'h0000_0000_0000_0002;
    rd(8'h00, v); check("R6 summary low bank only", v, 32'h0000_0100);
    periph_lvl = '1; local_lvl = '1;
    rd(8'h00, v); check("R7 summary all lines", v, exp_summary(periph_lvl, local_lvl));
    periph_lvl = '0; local_lvl = '0;
  endtask

  task automatic t_irq();
    clear_all();
    periph_lvl = 64'h0000_0020_0000_0000;
    settle();
    check("R10 irq low, line not enabled", {31'b0, irq_o}, 32'h0);
    wr(8'h14, 32'h0000_0020);
    settle();
    check("R10 irq high, enabled line", {31'b0, irq_o}, 32'h1);
    periph_lvl = '0; local_lvl = 8'h80;
    settle();
    check("R10 irq low, local not enabled", {31'b0, irq_o}, 32'h0);
    wr(8'h18, 32'h0000_0080);
    settle();
    check("R10 irq high, local line", {31'b0, irq_o}, 32'h1);
    local_lvl = '0;
    settle();
    check("R10 irq drops with line", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_fast();
    logic [31:0] v;
    clear_all();
    wr(8'h0C, 32'h0000_00AD);           // enable, select line 45
    rd(8'h0C, v); check("R8 fast control readback", v, 32'h0000_00AD);
    periph_lvl[45] = 1'b1;
    settle();
    check("R8 fiq follows unmasked line 45", {31'b0, fiq_o}, 32'h1);
    check("R8 irq stays low with mask clear", {31'b0, irq_o}, 32'h0);
    periph_lvl[45] = 1'b0;
    settle();
    check("R8 fiq drops with line 45", {31'b0, fiq_o}, 32'h0);
    wr(8'h0C, 32'h0000_00C2);           // enable, select local line 2
    local_lvl = 8'h04;
    settle();
    check("R8 fiq follows local line 2", {31'b0, fiq_o}, 32'h1);
    wr(8'h0C, 32'h0000_0042);           // fast enable off
    settle();
    check("R8 fiq low when disabled", {31'b0, fiq_o}, 32'h0);
    local_lvl = '0;
  endtask

  task automatic t_unmapped();
    periph_lvl = '1; local_lvl = '1;
    wr(8'h0C, 32'h0000_00C8);           // select 72
    settle();
    check("R9 select 72 keeps fiq low", {31'b0, fiq_o}, 32'h0);
    wr(8'h0C, 32'h0000_00FF);           // select 127
    settle();
    check("R9 select 127 keeps fiq low", {31'b0, fiq_o}, 32'h0);
    wr(8'h0C, 32'h0000_00C7);           // select 71 for contrast
    settle();
    check("R8 select 71 local line 7", {31'b0, fiq_o}, 32'h1);
    periph_lvl = '0; local_lvl = '0;
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_undef();
    logic [31:0] v;
    clear_all();
    wr(8'h10, 32'h0000_0003); m_en[31:0] = 32'h3;
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h12, 32'hFFFF_FFFF);           // misaligned
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h1D, 32'hFFFF_FFFF);           // misaligned clear
    rd(8'h10, v); check("R11 enable low untouched", v, 32'h0000_0003);
    rd(8'h14, v); check("R11 enable high untouched", v, 32'h0);
    rd(8'h18, v); check("R11 enable local untouched", v, 32'h0);
    rd(8'h0C, v); check("R11 fast control untouched", v, 32'h0);
    rd(8'h28, v); check("R11 undefined reads zero", v, 32'h0);
    rd(8'h11, v); check("R11 misaligned reads zero", v, 32'h0);
  endtask

  task automatic t_collide();
    clear_all();
    wr(8'h10, 32'h0000_0020); m_en[5] = 1'b1;
    settle();
    check("R12 irq low before collision", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    periph_lvl[5] = 1'b1;
    bus_we = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h0000_0020;
    @(posedge clk); #1;
    check("R12 irq sees line with old mask", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    @(posedge clk); #1;
    check("R3 R12 irq low after clear lands", {31'b0, irq_o}, 32'h0);
    periph_lvl = '0;
    // Selector write while chosen line already high
    local_lvl = 8'h01;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_00C0;
    @(posedge clk); #1;
    check("R12 fiq not yet set on select edge", {31'b0, fiq_o}, 32'h0);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    @(posedge clk); #1;
    check("R12 fiq set one edge later", {31'b0, fiq_o}, 32'h1);
    local_lvl = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_clear();
    t_disable_read();
    t_pending();
    t_summary();
    t_irq();
    t_fast();
    t_unmapped();
    t_undef();
    t_collide();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule